// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block is an event monitor for one processor core. It holds three 32-bit counters and one packed control word. Two of the counters are event counters: each one follows a single line out of a 256-line event input, chosen by an 8-bit index, and adds one on every clock in which that line is high. The third counter measures elapsed clocks. It advances on every clock, or once in every 64 clocks when the slow mode is on.

Software reaches the block through a word-wide register port. The port has a write strobe, a 2-bit address, write data, and read data that follows the address in the same cycle. Address 0 selects the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. Each counter can be preset to the negative of a sample interval N. It then wraps after N increments. A wrap sets a sticky overflow flag, and the single level-sensitive interrupt is raised for any flag whose enable bit is set. Software clears the flags by writing ones to them.

Control word layout: bit 0 is the run enable. Bit 1 is the event-counter clear strobe and bit 2 the cycle-counter clear strobe. Bit 3 selects divide-by-64 cycle counting. Bits 6:4 are the interrupt enables and bits 10:8 the overflow flags; within each group the order is event counter 0, event counter 1, cycle counter. Bits 19:12 hold the selector for event counter 1 and bits 27:20 the selector for event counter 0.

Top module: `perf_mon_unit`

## Requirements
- R1: While control bit 0 is low no counter changes except through a register write; while it is high the cycle counter (slow mode off) adds one per clock.
- R2: Writing 1 to control bit 1 zeroes both event counters, and writing 1 to bit 2 zeroes the cycle counter; neither bit is stored, and both read back as 0.
- R3: With control bit 3 set, the cycle counter adds one on every 64th enabled clock; a cycle-counter clear also restarts that 64-clock interval.
- R4: A counter that steps from all ones to zero sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter; the flag stays set until cleared.
- R5: Writing 1 to an overflow flag clears it, and writing 0 leaves it unchanged; if the same counter wraps in the clock of that write, the flag stays set.
- R6: The interrupt output is high exactly when some overflow flag is set together with its enable (bit 4 for event counter 0, bit 5 for event counter 1, bit 6 for the cycle counter).
- R7: Control bits 31:28, 7 and 11 always read 0, and writes to them have no effect.
- R8: A write to address 1, 2 or 3 loads the cycle counter, event counter 0 or event counter 1 respectively; a preset of -N wraps after N increments.
- R9: Event counter 0 counts clocks in which the event input bit indexed by control bits 27:20 is high; event counter 1 uses the index in bits 19:12; other event inputs have no effect.
- R10: A counter write in the same clock as an increment of that counter loads the written value unchanged.
- R11: After reset the control word, all flags, all counters and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| acc_wdata | input | 32 | Register write data |
| acc_rdata | output | 32 | Read data for the addressed register |
| evt_in | input | 256 | Single-cycle event pulses, one per line |
| irq | output | 1 | Level interrupt for enabled overflow flags |

## Verification
The hardest case to reach from the ports is a counter wrapping in the same clock as a control write that clears its flag. The bench first enables the cycle counter and then loads it with all ones while it runs. The next clock therefore wraps it, and the flag-clearing control write is placed on exactly that clock. The same run also checks that a load made while the counter is running is not followed by an increment. Slow mode is checked by holding the counter enabled for 128 clocks and expecting exactly two increments.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 8;
    localparam int EVT_W  = 1 << SEL_W;
    localparam int N_CNT  = 3;            // index 0: event 0, 1: event 1, 2: cycle

    localparam int B_EN      = 0;
    localparam int B_CLR_EVT = 1;
    localparam int B_CLR_CYC = 2;
    localparam int B_DIV     = 3;
    localparam int B_IE_LO   = 4;
    localparam int B_OVF_LO  = 8;
    localparam int B_SEL1_LO = 12;
    localparam int B_SEL0_LO = 20;

    // bits kept in the configuration register (enable, divide, enables, selectors)
    localparam logic [DATA_W-1:0] CFG_MASK = 32'h0FFF_F079;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CYC  = 2'd1,
        ADDR_EV0  = 2'd2,
        ADDR_EV1  = 2'd3
    } pmu_addr_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (clr)  q <= '0;
        else if (inc)  q <= q + 1'b1;
    end

    assign value = q;
    assign wrap  = inc && !load && !clr && (q == {W{1'b1}});
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
    parameter int RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PS_W = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(RATIO - 1);

    logic [PS_W-1:0] ps_q;

    assign tick = run && (ps_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)    ps_q <= '0;
        else if (clr)  ps_q <= '0;
        else if (tick) ps_q <= '0;
        else if (run)  ps_q <= ps_q + 1'b1;
    end
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_CNT-1:0]  wrap,
    output logic              en,
    output logic              div,
    output logic [SEL_W-1:0]  sel0,
    output logic [SEL_W-1:0]  sel1,
    output logic              clr_evt,
    output logic              clr_cyc,
    output logic [N_CNT-1:0]  ovf,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              irq
);
    logic [DATA_W-1:0] cfg_q;
    logic [N_CNT-1:0]  ovf_q;
    logic [N_CNT-1:0]  w1c;
    logic [N_CNT-1:0]  ie;

    assign w1c = wr ? wdata[B_OVF_LO +: N_CNT] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ovf_q <= '0;
        end else begin
            if (wr) cfg_q <= wdata & CFG_MASK;
            ovf_q <= (ovf_q & ~w1c) | wrap;
        end
    end

    assign en      = cfg_q[B_EN];
    assign div     = cfg_q[B_DIV];
    assign ie      = cfg_q[B_IE_LO +: N_CNT];
    assign sel0    = cfg_q[B_SEL0_LO +: SEL_W];
    assign sel1    = cfg_q[B_SEL1_LO +: SEL_W];
    assign clr_evt = wr && wdata[B_CLR_EVT];
    assign clr_cyc = wr && wdata[B_CLR_CYC];
    assign ovf     = ovf_q;

    always_comb begin
        ctrl_word = cfg_q;
        ctrl_word[B_OVF_LO +: N_CNT] = ovf_q;
    end

    assign irq = |(ovf_q & ie);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int DIV_RATIO = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic [1:0]        acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [EVT_W-1:0]  evt_in,
    output logic              irq
);
    logic              ctl_en, ctl_div, clr_evt, clr_cyc, slow_tick;
    logic [SEL_W-1:0]  sel0, sel1;
    logic [N_CNT-1:0]  ovf_flags, wrap_vec, inc_vec, load_vec, clr_vec;
    logic [DATA_W-1:0] ctrl_word;
    logic [CNT_W-1:0]  cnt_q [N_CNT];
    logic [CNT_W-1:0]  ev0_val, ev1_val, cyc_val;
    logic              wr_ctrl;

    assign wr_ctrl = acc_wr && (acc_addr == ADDR_CTRL);

    pmu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(acc_wdata),
        .wrap(wrap_vec), .en(ctl_en), .div(ctl_div), .sel0(sel0), .sel1(sel1),
        .clr_evt(clr_evt), .clr_cyc(clr_cyc), .ovf(ovf_flags),
        .ctrl_word(ctrl_word), .irq(irq)
    );

    pmu_prescale #(.RATIO(DIV_RATIO)) u_ps (
        .clk(clk), .rst_n(rst_n), .run(ctl_en && ctl_div), .clr(clr_cyc),
        .tick(slow_tick)
    );

    assign inc_vec[0]  = ctl_en && evt_in[sel0];
    assign inc_vec[1]  = ctl_en && evt_in[sel1];
    assign inc_vec[2]  = ctl_en && (!ctl_div || slow_tick);
    assign load_vec[0] = acc_wr && (acc_addr == ADDR_EV0);
    assign load_vec[1] = acc_wr && (acc_addr == ADDR_EV1);
    assign load_vec[2] = acc_wr && (acc_addr == ADDR_CYC);
    assign clr_vec     = {clr_cyc, clr_evt, clr_evt};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr_vec[g]), .load(load_vec[g]),
            .load_val(acc_wdata[CNT_W-1:0]), .inc(inc_vec[g]),
            .value(cnt_q[g]), .wrap(wrap_vec[g])
        );
    end

    assign ev0_val = cnt_q[0];
    assign ev1_val = cnt_q[1];
    assign cyc_val = cnt_q[2];

    always_comb begin
        unique case (acc_addr)
            ADDR_CTRL: acc_rdata = ctrl_word;
            ADDR_CYC:  acc_rdata = DATA_W'(cyc_val);
            ADDR_EV0:  acc_rdata = DATA_W'(ev0_val);
            ADDR_EV1:  acc_rdata = DATA_W'(ev1_val);
            default:   acc_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_wr,
    input logic [1:0]       acc_addr,
    input logic [31:0]      acc_wdata,
    input logic             irq,
    input logic             en,
    input logic [2:0]       ovf,
    input logic [2:0]       wrap,
    input logic [CNT_W-1:0] cyc_cnt,
    input logic [CNT_W-1:0] ev0_cnt,
    input logic [CNT_W-1:0] ev1_cnt
);
    a_r1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !acc_wr) |=> ($stable(cyc_cnt) && $stable(ev0_cnt) && $stable(ev1_cnt)));

    a_r2_cyc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == 2'd0 && acc_wdata[2]) |=> (cyc_cnt == '0));

    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap != 3'b000) |=> ((ovf & $past(wrap)) == $past(wrap)));

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[2] |=> (cyc_cnt == '0));

    a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == 2'd0 && acc_wdata[8] && !wrap[0]) |=> !ovf[0]);

    a_r6_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf == 3'b000) |-> !irq);

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == 2'd2) |=> (ev0_cnt == $past(acc_wdata[CNT_W-1:0])));
endmodule

bind perf_mon_unit pmu_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .irq(irq), .en(ctl_en), .ovf(ovf_flags),
    .wrap(wrap_vec), .cyc_cnt(cyc_val), .ev0_cnt(ev0_val), .ev1_cnt(ev1_val)
);

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_CYC = 2'd1, A_EV0 = 2'd2, A_EV1 = 2'd3;
    localparam int K_DATA = 0, K_IRQ = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_addr = 2'd0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [255:0] evt_in = '0;
    logic        irq;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_mon_unit dut (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .evt_in(evt_in), .irq(irq)
    );

    // monitor: compares pending expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = (it.kind == K_IRQ) ? {31'b0, irq} : acc_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(posedge clk); #1;
        acc_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input int kind, input logic [1:0] a, input logic [31:0] e, input string tag);
        acc_addr = a;
        sb_q.push_back('{kind, e, tag});
        @(posedge clk); #1;
    endtask

    localparam logic [31:0] SEL0_5   = 32'd5 << 20;
    localparam logic [31:0] SEL1_200 = 32'd200 << 12;
    localparam logic [31:0] SEL1_6   = 32'd6 << 12;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        chk(K_DATA, A_CTRL, 32'h0, "R11 ctrl");
        chk(K_DATA, A_CYC,  32'h0, "R11 cyc");
        chk(K_DATA, A_EV0,  32'h0, "R11 ev0");
        chk(K_DATA, A_EV1,  32'h0, "R11 ev1");
        chk(K_IRQ,  A_CTRL, 32'h0, "R11 irq");

        // R7 write-as-zero bits
        wr(A_CTRL, 32'hF000_0880);
        chk(K_DATA, A_CTRL, 32'h0, "R7 reserved bits");
        chk(K_IRQ,  A_CTRL, 32'h0, "R7 irq");

        // R1 cycle counting and gating
        wr(A_CTRL, 32'h1);
        idle(5);
        wr(A_CTRL, 32'h0);
        chk(K_DATA, A_CYC, 32'd6, "R1 counted");
        idle(3);
        chk(K_DATA, A_CYC, 32'd6, "R1 frozen");

        // R2 cycle clear strobe
        wr(A_CTRL, 32'h4);
        chk(K_DATA, A_CYC,  32'd0, "R2 cyc clear");
        chk(K_DATA, A_CTRL, 32'h0, "R2 strobe reads 0");

        // R9 event selection
        evt_in[5] = 1'b1; evt_in[6] = 1'b1;
        wr(A_CTRL, SEL0_5 | SEL1_200 | 32'h1);
        idle(3);
        wr(A_CTRL, SEL0_5 | SEL1_200);
        chk(K_DATA, A_EV0, 32'd4, "R9 ev0 sel 5");
        chk(K_DATA, A_EV1, 32'd0, "R9 ev1 sel 200 idle");
        chk(K_DATA, A_CYC, 32'd4, "R1 cyc alongside");
        wr(A_CTRL, SEL1_6 | 32'h1);
        idle(1);
        wr(A_CTRL, 32'h0);
        chk(K_DATA, A_EV1, 32'd2, "R9 ev1 sel 6");
        chk(K_DATA, A_EV0, 32'd4, "R9 ev0 unselected");

        // R2 event clear strobe
        wr(A_CTRL, 32'h2);
        chk(K_DATA, A_EV0, 32'd0, "R2 ev0 clear");
        chk(K_DATA, A_EV1, 32'd0, "R2 ev1 clear");
        chk(K_DATA, A_CYC, 32'd6, "R2 cyc untouched");

        // R8 preset -2, R4 flag, R6 irq
        wr(A_EV0, 32'hFFFF_FFFE);
        wr(A_CTRL, SEL0_5 | 32'h11);
        idle(2);
        wr(A_CTRL, SEL0_5 | 32'h10);
        chk(K_DATA, A_EV0,  32'd1, "R8 preset wrap");
        chk(K_DATA, A_CTRL, SEL0_5 | 32'h110, "R4 ev0 flag");
        chk(K_IRQ,  A_CTRL, 32'h1, "R6 irq ev0");

        // R5 write-one-to-clear
        wr(A_CTRL, SEL0_5 | 32'h110);
        chk(K_DATA, A_CTRL, SEL0_5 | 32'h10, "R5 flag cleared");
        chk(K_IRQ,  A_CTRL, 32'h0, "R6 irq dropped");

        // R4 cycle overflow, R6 masking
        evt_in = '0;
        wr(A_CYC, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1);
        idle(1);
        wr(A_CTRL, 32'h0);
        chk(K_DATA, A_CYC,  32'd1, "R4 cyc wrapped");
        chk(K_DATA, A_CTRL, 32'h400, "R4 cyc flag");
        chk(K_IRQ,  A_CTRL, 32'h0, "R6 masked");
        wr(A_CTRL, 32'h40);
        chk(K_IRQ,  A_CTRL, 32'h1, "R6 unmasked");
        wr(A_CTRL, 32'h400);
        chk(K_DATA, A_CTRL, 32'h0, "R5 cyc flag cleared");
        chk(K_IRQ,  A_CTRL, 32'h0, "R6 low again");

        // R10 load priority, R5 wrap wins over clear
        wr(A_CTRL, 32'h41);
        wr(A_CYC, 32'h10);
        chk(K_DATA, A_CYC, 32'h10, "R10 load beats increment");
        wr(A_CYC, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h441);
        wr(A_CTRL, 32'h40);
        chk(K_DATA, A_CTRL, 32'h440, "R5 wrap beats clear");
        chk(K_IRQ,  A_CTRL, 32'h1, "R6 irq held");
        chk(K_DATA, A_CYC,  32'd1, "R10 count after wrap");
        wr(A_CTRL, 32'h400);

        // R3 divide by 64
        wr(A_CTRL, 32'h4);
        wr(A_CTRL, 32'h9);
        idle(127);
        wr(A_CTRL, 32'h8);
        chk(K_DATA, A_CYC,  32'd2, "R3 slow count");
        chk(K_DATA, A_CTRL, 32'h8, "R3 mode bit");

        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule